// File: doc/BRIEF.md
# Line and Frame Sync with Keyboard Input Port

This block sits beside an 8-bit CPU that draws a character display in software. It makes the two sync levels a composite video signal needs, and it serves the one input port that reads the key matrix. The horizontal sync pulse starts when the CPU acknowledges an interrupt. It then lasts for a set number of opcode fetches, so its length follows the CPU's own instruction timing and no separate timer is needed. The frame sync level is a single flip-flop. An I/O write turns it off and an even-address I/O read turns it on, with no other address decoding. The software makes the frame sync pulse by reading the keyboard and then writing to any port.

The same even-address read puts a byte on the CPU data bus. That byte holds five column lines from an 8-row by 5-column key matrix, the cassette input, and a bit that tells 50 Hz from 60 Hz frames. The upper address byte chooses which rows are scanned. The OR of the two sync levels gives the combined sync, which also drives the cassette output.

All strobes are active low and are sampled on `clk`, which runs at the CPU T-state rate. The sync levels are registered. The read byte is combinational from the current strobes, address and inputs.

Top module: `sync_kbd_port`

## Requirements
- R1: After reset `hsync`, `vsync`, `csync` and `tape_out` are 0, and `rd_data` is 8'hFF while no I/O read is in progress.
- R2: A cycle with `m1_n` and `iorq_n` both low (interrupt acknowledge) makes `hsync` 1 from the next clock edge.
- R3: After an acknowledge, `hsync` stays 1 until the clock edge that samples the HS_PULSES-th rising edge of `m1_n`, and goes to 0 at that edge. The default HS_PULSES of 5 gives 20 T-states with 4-state fetches.
- R4: An I/O write (`iorq_n`, `wr_n` low, `m1_n` high) to any address makes `vsync` 0 from the next edge.
- R5: An I/O read (`iorq_n`, `rd_n` low, `m1_n` high) with `addr[0]`=0 makes `vsync` 1 from the next edge. A read with `addr[0]`=1 leaves `vsync` unchanged.
- R6: During an even-address I/O read, `rd_data[c]` (c=0..4) is 0 exactly when some row r with `addr[8+r]`=0 has `keys[r*5+c]`=1 (1 = pressed).
- R7: A high address byte of 8'h00 selects all rows, so a pressed key anywhere clears its column bit.
- R8: During an even-address I/O read, `rd_data[7]` equals `tape_in`, `rd_data[6]` is 0 when `region_60`=1 and 1 when it is 0, and `rd_data[5]` is 1.
- R9: `rd_data` is 8'hFF whenever no even-address I/O read is in progress, including odd-address reads and writes.
- R10: `csync` is `hsync` OR `vsync`, and `tape_out` equals `csync`.
- R11: I/O strobes seen while `m1_n` is low count as an acknowledge and not as a port access. They neither set `vsync` nor drive key data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 16 | CPU address bus |
| keys | input | 40 | Key matrix state, bit r*5+c is row r column c, 1 = pressed |
| tape_in | input | 1 | Cassette input level |
| region_60 | input | 1 | Region jumper fitted (60 Hz frames) |
| hsync | output | 1 | Horizontal sync level, active high |
| vsync | output | 1 | Vertical sync level, active high |
| csync | output | 1 | Combined sync, active high |
| tape_out | output | 1 | Cassette output, follows combined sync |
| rd_data | output | 8 | Read data for the CPU data bus |

## Verification
The read port is driven from a table of row selections. These are all rows, none, one row, and a scattered set. Each is paired with key patterns that put pressed keys inside and outside the selected rows. This separates correct row gating from a plain OR of the whole matrix, and it catches a swapped row or column index. Tape and jumper values change from row to row so that the fixed bits cannot be stuck. Directed sequences run an acknowledge followed by 4-state fetches and check that `hsync` lasts exactly five `m1_n` rises. Further sequences apply writes, odd reads and reads with `m1_n` low, which separates real frame-sync set and clear events from strobes that only look like them.

// File: rtl/sync_kbd_pkg.sv
package sync_kbd_pkg;

  typedef struct packed {
    logic intack;      // interrupt acknowledge cycle
    logic port_rd;     // even-address I/O read
    logic port_wr;     // any I/O write
  } bus_ev_t;

  // Classify the current strobe pattern. An opcode-fetch strobe overrides
  // port decoding: with m1_n low the request is an acknowledge.
  function automatic bus_ev_t decode_bus(input logic m1_n, input logic iorq_n,
                                         input logic rd_n, input logic wr_n,
                                         input logic a0);
    bus_ev_t ev;
    ev.intack  = !m1_n && !iorq_n;
    ev.port_rd =  m1_n && !iorq_n && !rd_n && !a0;
    ev.port_wr =  m1_n && !iorq_n && !wr_n;
    return ev;
  endfunction

  // Combine one column: the line is pulled low by any pressed key whose
  // row strobe (active low) is asserted.
  function automatic logic column_level(input logic [7:0] col_keys,
                                        input logic [7:0] row_sel_n,
                                        input int         rows);
    logic hit;
    hit = 1'b0;
    for (int r = 0; r < 8; r++) begin
      if (r < rows) hit = hit | (col_keys[r] & ~row_sel_n[r]);
    end
    return ~hit;
  endfunction

endpackage

// File: rtl/line_sync_gen.sv
module line_sync_gen #(
  parameter int HS_PULSES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic m1_n,
  input  logic intack,
  output logic hsync,
  output logic m1_rise
);
  localparam int CW = $clog2(HS_PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(HS_PULSES - 1);

  logic          m1_prev;
  logic [CW-1:0] rise_cnt;

  // rising edge of the fetch strobe, i.e. end of an opcode fetch
  assign m1_rise = m1_n && !m1_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1_prev  <= 1'b1;
      hsync    <= 1'b0;
      rise_cnt <= '0;
    end else begin
      m1_prev <= m1_n;
      if (intack) begin
        hsync    <= 1'b1;
        rise_cnt <= '0;
      end else if (hsync && m1_rise) begin
        if (rise_cnt == LAST) begin
          hsync    <= 1'b0;
          rise_cnt <= '0;
        end else begin
          rise_cnt <= rise_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frame_sync_ff.sv
module frame_sync_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic vsync
);
  always_ff @(posedge clk) begin
    if (!rst_n)       vsync <= 1'b0;
    else if (clr_ev)  vsync <= 1'b0;
    else if (set_ev)  vsync <= 1'b1;
  end
endmodule

// File: rtl/key_port.sv
module key_port
  import sync_kbd_pkg::*;
#(
  parameter int ROWS = 8,   // 1..8
  parameter int COLS = 5    // 1..5
) (
  input  logic                 sel,
  input  logic [ROWS-1:0]      row_sel_n,
  input  logic [ROWS*COLS-1:0] keys,
  input  logic                 tape_in,
  input  logic                 region_60,
  output logic [7:0]           rd_data
);
  logic [COLS-1:0] col_n;
  logic [7:0]      row_sel_pad;

  always_comb begin
    row_sel_pad = 8'hFF;
    row_sel_pad[ROWS-1:0] = row_sel_n;
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [7:0] col_keys;
    always_comb begin
      col_keys = 8'h00;
      for (int r = 0; r < ROWS; r++) col_keys[r] = keys[r*COLS + c];
      col_n[c] = column_level(col_keys, row_sel_pad, ROWS);
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    if (sel) begin
      rd_data[COLS-1:0] = col_n;
      rd_data[6]        = ~region_60;
      rd_data[7]        = tape_in;
    end
  end
endmodule

// File: rtl/sync_kbd_port.sv
module sync_kbd_port
  import sync_kbd_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int ROWS      = 8,
  parameter int COLS      = 5,
  parameter int HS_PULSES = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 m1_n,
  input  logic                 iorq_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [ROWS*COLS-1:0] keys,
  input  logic                 tape_in,
  input  logic                 region_60,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 csync,
  output logic                 tape_out,
  output logic [7:0]           rd_data
);
  localparam int ROW_BASE = ADDR_W - 8;

  bus_ev_t ev;
  logic    intack_w;
  logic    port_rd_w;
  logic    port_wr_w;
  logic    m1_rise_w;
  logic    unused_addr_bits;

  assign ev        = decode_bus(m1_n, iorq_n, rd_n, wr_n, addr[0]);
  assign intack_w  = ev.intack;
  assign port_rd_w = ev.port_rd;
  assign port_wr_w = ev.port_wr;
  assign unused_addr_bits = ^addr[ROW_BASE-1:1] ^ ^addr[ADDR_W-1:ROW_BASE+ROWS-1];

  line_sync_gen #(.HS_PULSES(HS_PULSES)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .m1_n    (m1_n),
    .intack  (intack_w),
    .hsync   (hsync),
    .m1_rise (m1_rise_w)
  );

  frame_sync_ff u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (port_rd_w),
    .clr_ev (port_wr_w),
    .vsync  (vsync)
  );

  key_port #(.ROWS(ROWS), .COLS(COLS)) u_keys (
    .sel       (port_rd_w),
    .row_sel_n (addr[ROW_BASE +: ROWS]),
    .keys      (keys),
    .tape_in   (tape_in),
    .region_60 (region_60),
    .rd_data   (rd_data)
  );

  assign csync    = hsync | vsync;
  assign tape_out = csync;
endmodule

// File: rtl/sync_kbd_port_chk.sv
module sync_kbd_port_chk #(
  parameter int HS_PULSES = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       m1_n,
  input logic       iorq_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       a0,
  input logic       tape_in,
  input logic       m1_rise_w,
  input logic       hsync,
  input logic       vsync,
  input logic [7:0] rd_data
);
  localparam int CW = $clog2(HS_PULSES + 1);
  localparam logic [CW-1:0] LAST = CW'(HS_PULSES - 1);

  logic          ack, prd, pwr;
  logic [CW-1:0] seen;

  assign ack = !m1_n && !iorq_n;
  assign prd =  m1_n && !iorq_n && !rd_n && !a0;
  assign pwr =  m1_n && !iorq_n && !wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n || ack)             seen <= '0;
    else if (hsync && m1_rise_w)   seen <= (seen == LAST) ? '0 : seen + 1'b1;
  end

  p_hsync_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> hsync);
  p_hsync_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hsync && !ack && m1_rise_w && seen == LAST |=> !hsync);
  p_hsync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hsync && !ack && !(m1_rise_w && seen == LAST) |=> hsync);
  p_vsync_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pwr |=> !vsync);
  p_vsync_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prd |=> vsync);
  p_vsync_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !prd && !pwr |=> $stable(vsync));
  p_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !prd |-> rd_data == 8'hFF);
  p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prd |-> rd_data[5] && rd_data[7] == tape_in);
endmodule

bind sync_kbd_port sync_kbd_port_chk #(.HS_PULSES(HS_PULSES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m1_n      (m1_n),
  .iorq_n    (iorq_n),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .a0        (addr[0]),
  .tape_in   (tape_in),
  .m1_rise_w (m1_rise_w),
  .hsync     (hsync),
  .vsync     (vsync),
  .rd_data   (rd_data)
);

// File: tb/sync_kbd_port_bench.sv
module sync_kbd_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m1_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [39:0] keys = '0;
  logic        tape_in = 1'b0, region_60 = 1'b0;
  logic        hsync, vsync, csync, tape_out;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_kbd_port u_sync_kbd_port (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .keys(keys), .tape_in(tape_in),
    .region_60(region_60), .hsync(hsync), .vsync(vsync), .csync(csync),
    .tape_out(tape_out), .rd_data(rd_data)
  );

  // {high address byte, keys, tape_in, region_60, expected rd_data}
  localparam int NV = 9;
  localparam logic [57:0] VEC [NV] = '{
    {8'h00, 40'h00_0000_0000, 1'b0, 1'b0, 8'h7F},  // R7 nothing pressed
    {8'hFE, 40'h00_0000_0001, 1'b1, 1'b0, 8'hFE},  // R6 row 0, col 0
    {8'hFD, 40'h00_0000_0001, 1'b0, 1'b1, 8'h3F},  // R6 key outside row
    {8'h00, 40'h80_0000_0000, 1'b1, 1'b0, 8'hEF},  // R7 row 7 col 4
    {8'h7F, 40'h20_0001_0000, 1'b0, 1'b0, 8'h7B},  // R6 row 7 col 2
    {8'hF7, 40'h20_0001_0000, 1'b1, 1'b1, 8'hBD},  // R6 row 3 col 1
    {8'hFF, 40'hFF_FFFF_FFFF, 1'b1, 1'b0, 8'hFF},  // R6 no row selected
    {8'h00, 40'hFF_FFFF_FFFF, 1'b0, 1'b1, 8'h20},  // R7 all pressed
    {8'hAA, 40'h00_0000_2020, 1'b0, 1'b0, 8'h77}   // R6 rows 0,2,4,6
  };

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    m1_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 hsync", hsync, 0);
    check("R1 vsync", vsync, 0);
    check("R1 csync", csync, 0);
    check("R1 tape_out", tape_out, 0);
    check("R1 rd_data", rd_data, 8'hFF);
    @(negedge clk); rst_n = 1'b1;
    step();

    // table of keyboard reads (R6 R7 R8), each also sets vsync (R5)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle(); wr_n = 1'b0; iorq_n = 1'b0; addr = 16'h0001;
      step();
      check("R4 vsync cleared", vsync, 0);
      @(negedge clk);
      idle();
      addr      = {VEC[i][57:50], 8'hFE};
      keys      = VEC[i][49:10];
      tape_in   = VEC[i][9];
      region_60 = VEC[i][8];
      iorq_n = 1'b0; rd_n = 1'b0;
      #1 check("R6 R8 key byte", rd_data, VEC[i][7:0]);
      step();
      check("R5 vsync set", vsync, 1);
      check("R10 csync with vsync", {csync, tape_out}, 2'b11);
      @(negedge clk); idle();
      #1 check("R9 idle byte", rd_data, 8'hFF);
    end

    // R5 odd read leaves vsync set, and returns 8'hFF (R9)
    @(negedge clk); iorq_n = 1'b0; rd_n = 1'b0; addr = 16'h0001; keys = '1;
    #1 check("R9 odd read byte", rd_data, 8'hFF);
    step(); check("R5 odd read keeps vsync", vsync, 1);
    // R4 write to even address clears
    @(negedge clk); idle(); iorq_n = 1'b0; wr_n = 1'b0; addr = 16'h0000;
    #1 check("R9 write byte", rd_data, 8'hFF);
    step(); check("R4 even write clears", vsync, 0);
    // R5 odd read does not set
    @(negedge clk); idle(); iorq_n = 1'b0; rd_n = 1'b0; addr = 16'h00FF;
    step(); check("R5 odd read no set", vsync, 0);
    // R11 strobes with m1_n low: no set, no data
    @(negedge clk); idle(); m1_n = 1'b0; iorq_n = 1'b0; rd_n = 1'b0;
    addr = 16'h0000;
    #1 check("R11 no key data", rd_data, 8'hFF);
    step(); check("R11 vsync untouched", vsync, 0);
    check("R2 hsync from acknowledge", hsync, 1);
    @(negedge clk); idle();
    // let that pulse end: 5 fetch ends
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); m1_n = 1'b0; step();
      @(negedge clk); m1_n = 1'b1; step();
    end
    check("R3 pulse ended", hsync, 0);

    // R2 R3 clean acknowledge then 4-state fetches
    @(negedge clk); m1_n = 1'b0; iorq_n = 1'b0;
    step();
    check("R2 hsync after acknowledge", hsync, 1);
    check("R10 csync with hsync", {csync, tape_out}, 2'b11);
    @(negedge clk); iorq_n = 1'b1;            // m1_n stays low
    step();
    @(negedge clk); m1_n = 1'b1;
    step();                                   // rise 1
    check("R3 hsync after rise 1", hsync, 1);
    for (int k = 2; k <= 5; k++) begin
      @(negedge clk); m1_n = 1'b1; step();
      @(negedge clk); m1_n = 1'b0; step();
      @(negedge clk); m1_n = 1'b0; step();
      @(negedge clk); m1_n = 1'b1; step();    // rise k
      if (k < 5) check("R3 hsync held", hsync, 1);
      else       check("R3 hsync ends at rise 5", hsync, 0);
    end
    check("R10 csync idle", {csync, tape_out}, 2'b00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule